// File: doc/BRIEF.md
# Serial NOR Flash Erase and Program Sequencer

This block runs whole erase and program jobs on a serial NOR flash over a single-bit SPI bus, so that no processor has to step through the flash protocol byte by byte. The host sets a start address, a byte count and the kind of job, then pulses `start`. For each step the engine sends the opcodes, frames chip select, shifts the bytes and polls the flash status register. It reports completion with a one-cycle `done` pulse. While the job runs, `busy` stays high.

An erase job covers a range of 1 KB sectors. Each sector gets its own full sequence: write-enable, a wait for the write-enable latch, the sector erase, a wait for the busy bit to clear, then write-disable and a wait for a fully idle status. A program job sends its data two bytes at a time with auto-increment word programming. Only the first word carries the address. Chip select rises after every word, and busy is polled before the next word. The engine fetches each data byte from the host through a byte-read port: it drives a byte offset and reads the byte back in the same cycle.

Status polling has no timeout. A request the engine cannot carry out is refused, and the error flag is raised.

Top module: `spi_flash_prog_seq`

## Requirements
- R1: During reset and after it, until a job is accepted, `spiCsN` is 1, `spiSck` is 0, and `busy`, `done` and `err` are 0.
- R2: The bus uses SPI mode 0. `spiSck` idles low whenever `spiCsN` is high. Bytes go out MSB first, and MOSI changes only on falling edges. Between two transactions, `spiCsN` stays high for at least 2*CLK_DIV system clocks.
- R3: A job begins with a one-byte transaction 0x06. It then repeats the two-byte transaction {0x05, 0x00} until status bits [1:0] read 2'b10.
- R4: After that, an erase (`opProg`=0) sends {0xD7, addr[23:16], addr[15:8], addr[7:0]}. It then repeats {0x05, 0x00} until status bit 0 reads 0.
- R5: An erase of N*1024 bytes runs the full sequence once per sector. The sector address starts at `startAddr` and grows by 0x400 each time.
- R6: A program job (`opProg`=1) first sends {0xAD, addr[23:16], addr[15:8], addr[7:0], d0, d1}. It then polls until status bit 0 is 0.
- R7: Each later word is sent as {0xAD, d(2k), d(2k+1)} and is followed by a busy poll. Byte dk is the value read at `bufAddr`=k. No 0xAD follows the last word.
- R8: Every job ends with a one-byte transaction 0x04. It then repeats {0x05, 0x00} until status bits [1:0] read 2'b00.
- R9: A poll repeats for as long as the status does not match, with no limit on the number of tries.
- R10: A request is refused when it asks for zero bytes, for an odd program length, or for an erase whose address or length is not a multiple of 1024. A refused request causes no chip-select activity, and `busy` stays 0. `err` is 1 from the next cycle until the next accepted start.
- R11: `start` is ignored while `busy` is 1.
- R12: `busy` is 1 from the cycle after an accepted start. `done` is a one-cycle pulse when the final idle poll matches, and in that same cycle `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Job request pulse |
| opProg | input | 1 | 1 = program, 0 = erase |
| startAddr | input | 24 | Flash start address |
| byteLen | input | LEN_W | Byte count of the job |
| bufAddr | output | LEN_W | Byte offset of the program data being fetched |
| bufData | input | 8 | Program data byte at `bufAddr` (same cycle) |
| spiSck | output | 1 | SPI clock |
| spiCsN | output | 1 | SPI chip select, active low |
| spiMosi | output | 1 | SPI data to flash |
| spiMiso | input | 1 | SPI data from flash |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was refused |

## Verification
The bench models a flash that reports busy for a configurable number of status reads. It decodes every chip-select frame and compares the frames with a sequence built independently from the requirements.

Several corner cases are targeted. Jobs whose polls need several tries catch an engine that gives up early or checks the wrong status bits, which would skip frames. A one-word program catches a stray trailing 0xAD. A multi-sector erase catches address stepping that drops or repeats a sector. Misaligned, odd and zero-length requests must leave the bus silent, and a `start` pulsed mid-job must not add a second `done` or any extra frames.

// File: rtl/flashseq_pkg.sv
package flashseq_pkg;

  localparam int SECTOR_BYTES = 1024;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_SECT = 8'hD7;
  localparam logic [7:0] OPC_WORD = 8'hAD;

  typedef enum logic [2:0] {
    SEL_OPC,
    SEL_AHI,
    SEL_AMID,
    SEL_ALO,
    SEL_DATA
  } txSel_e;

  typedef struct packed {
    logic       csOn;
    logic       csOff;
    logic       kick;
    txSel_e     txSel;
    logic [7:0] opcode;
    logic       loadOp;
    logic       advByte;
    logic       advSector;
  } dpCtrl_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WREN,
    ST_PWEL,
    ST_ERASE,
    ST_PFIRST,
    ST_PNEXT,
    ST_PBUSY,
    ST_WRDI,
    ST_PIDLE
  } seqState_e;

endpackage

// File: rtl/flashseq_dp.sv
module flashseq_dp
  import flashseq_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int LEN_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [23:0]      startAddr,
  input  logic [LEN_W-1:0] byteLen,
  input  logic [7:0]       bufData,
  input  logic             spiMiso,
  output logic [LEN_W-1:0] bufAddr,
  output logic             spiSck,
  output logic             spiCsN,
  output logic             spiMosi,
  output logic             byteDone,
  output logic [7:0]       rxByte,
  output logic             gapBusy,
  output logic             remZero,
  output logic             lastSector
);

  localparam int DIV_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int GAP_CYC = 2 * CLK_DIV;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic             active;
  logic [7:0]       txSh;
  logic [7:0]       rxSh;
  logic [GAP_W-1:0] gapCnt;
  logic [23:0]      curAddr;
  logic [LEN_W-1:0] remLen;
  logic [LEN_W-1:0] bufIdx;
  logic [7:0]       txByte;

  always_comb begin
    unique case (ctl.txSel)
      SEL_AHI:  txByte = curAddr[23:16];
      SEL_AMID: txByte = curAddr[15:8];
      SEL_ALO:  txByte = curAddr[7:0];
      SEL_DATA: txByte = bufData;
      default:  txByte = ctl.opcode;
    endcase
  end

  // bit shifter, mode 0: launch on falling edge, capture on rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      bitCnt   <= '0;
      active   <= 1'b0;
      txSh     <= '0;
      rxSh     <= '0;
      spiSck   <= 1'b0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (ctl.kick) begin
        active <= 1'b1;
        txSh   <= txByte;
        divCnt <= '0;
        bitCnt <= '0;
      end else if (active) begin
        if (divCnt == DIV_W'(CLK_DIV - 1)) begin
          divCnt <= '0;
          if (!spiSck) begin
            spiSck <= 1'b1;
            rxSh   <= {rxSh[6:0], spiMiso};
          end else begin
            spiSck <= 1'b0;
            txSh   <= {txSh[6:0], 1'b0};
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              active   <= 1'b0;
              byteDone <= 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  // chip select framing and deselect gap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spiCsN <= 1'b1;
      gapCnt <= '0;
    end else if (ctl.csOn) begin
      spiCsN <= 1'b0;
    end else if (ctl.csOff) begin
      spiCsN <= 1'b1;
      gapCnt <= GAP_W'(GAP_CYC);
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - GAP_W'(1);
    end
  end

  // address, remaining length and buffer index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      remLen  <= '0;
      bufIdx  <= '0;
    end else if (ctl.loadOp) begin
      curAddr <= startAddr;
      remLen  <= byteLen;
      bufIdx  <= '0;
    end else if (ctl.advSector) begin
      curAddr <= curAddr + 24'(SECTOR_BYTES);
      remLen  <= remLen - LEN_W'(SECTOR_BYTES);
    end else if (ctl.advByte) begin
      bufIdx <= bufIdx + LEN_W'(1);
      remLen <= remLen - LEN_W'(1);
    end
  end

  assign spiMosi    = txSh[7];
  assign rxByte     = rxSh;
  assign gapBusy    = (gapCnt != '0);
  assign remZero    = (remLen == '0);
  assign lastSector = (remLen == LEN_W'(SECTOR_BYTES));
  assign bufAddr    = bufIdx;

endmodule

// File: rtl/flashseq_ctrl.sv
module flashseq_ctrl
  import flashseq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             opProg,
  input  logic [23:0]      startAddr,
  input  logic [LEN_W-1:0] byteLen,
  input  logic             byteDone,
  input  logic [7:0]       rxByte,
  input  logic             gapBusy,
  input  logic             remZero,
  input  logic             lastSector,
  output dpCtrl_t          ctl,
  output logic             busy,
  output logic             done,
  output logic             err
);

  seqState_e  state, nState;
  logic       shifting, nShift;
  logic [2:0] byteIdx, nIdx;
  logic       progMode;
  logic       finish;
  logic       reqValid;
  logic       statusOk;

  function automatic logic [2:0] lastIdx(seqState_e s);
    case (s)
      ST_WREN, ST_WRDI: return 3'd0;
      ST_ERASE:         return 3'd3;
      ST_PFIRST:        return 3'd5;
      ST_PNEXT:         return 3'd2;
      default:          return 3'd1;
    endcase
  endfunction

  function automatic txSel_e selFor(seqState_e s, logic [2:0] idx);
    if (idx == 3'd0) return SEL_OPC;
    case (s)
      ST_ERASE, ST_PFIRST:
        case (idx)
          3'd1:    return SEL_AHI;
          3'd2:    return SEL_AMID;
          3'd3:    return SEL_ALO;
          default: return SEL_DATA;
        endcase
      ST_PNEXT: return SEL_DATA;
      default:  return SEL_OPC;
    endcase
  endfunction

  function automatic logic [7:0] opcodeFor(seqState_e s, logic [2:0] idx);
    if (idx != 3'd0) return 8'h00;
    case (s)
      ST_WREN:             return OPC_WREN;
      ST_WRDI:             return OPC_WRDI;
      ST_ERASE:            return OPC_SECT;
      ST_PFIRST, ST_PNEXT: return OPC_WORD;
      default:             return OPC_RDSR;
    endcase
  endfunction

  assign reqValid = (byteLen != '0) &&
                    (opProg ? !byteLen[0]
                            : (startAddr[9:0] == 10'd0 && byteLen[9:0] == 10'd0));

  always_comb begin
    case (state)
      ST_PWEL:  statusOk = (rxByte[1:0] == 2'b10);
      ST_PBUSY: statusOk = !rxByte[0];
      default:  statusOk = (rxByte[1:0] == 2'b00);
    endcase
  end

  always_comb begin
    ctl    = '0;
    nState = state;
    nShift = shifting;
    nIdx   = byteIdx;
    finish = 1'b0;
    if (state == ST_IDLE) begin
      if (start && reqValid) begin
        ctl.loadOp = 1'b1;
        nState     = ST_WREN;
        nShift     = 1'b0;
      end
    end else if (!shifting) begin
      if (!gapBusy) begin
        ctl.csOn   = 1'b1;
        ctl.kick   = 1'b1;
        ctl.txSel  = SEL_OPC;
        ctl.opcode = opcodeFor(state, 3'd0);
        nIdx       = 3'd0;
        nShift     = 1'b1;
      end
    end else if (byteDone) begin
      if (byteIdx != lastIdx(state)) begin
        nIdx        = byteIdx + 3'd1;
        ctl.kick    = 1'b1;
        ctl.txSel   = selFor(state, nIdx);
        ctl.opcode  = opcodeFor(state, nIdx);
        ctl.advByte = (selFor(state, nIdx) == SEL_DATA);
      end else begin
        ctl.csOff = 1'b1;
        nShift    = 1'b0;
        case (state)
          ST_WREN:  nState = ST_PWEL;
          ST_PWEL:  if (statusOk) nState = progMode ? ST_PFIRST : ST_ERASE;
          ST_ERASE, ST_PFIRST, ST_PNEXT: nState = ST_PBUSY;
          ST_PBUSY: if (statusOk) nState = (progMode && !remZero) ? ST_PNEXT : ST_WRDI;
          ST_WRDI:  nState = ST_PIDLE;
          ST_PIDLE:
            if (statusOk) begin
              if (!progMode && !lastSector) begin
                ctl.advSector = 1'b1;
                nState        = ST_WREN;
              end else begin
                nState = ST_IDLE;
                finish = 1'b1;
              end
            end
          default: nState = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      shifting <= 1'b0;
      byteIdx  <= '0;
      progMode <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      state    <= nState;
      shifting <= nShift;
      byteIdx  <= nIdx;
      done     <= finish;
      if (ctl.loadOp) progMode <= opProg;
      if (state == ST_IDLE && start) err <= !reqValid;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/spi_flash_prog_seq.sv
module spi_flash_prog_seq
  import flashseq_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int LEN_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             opProg,
  input  logic [23:0]      startAddr,
  input  logic [LEN_W-1:0] byteLen,
  output logic [LEN_W-1:0] bufAddr,
  input  logic [7:0]       bufData,
  output logic             spiSck,
  output logic             spiCsN,
  output logic             spiMosi,
  input  logic             spiMiso,
  output logic             busy,
  output logic             done,
  output logic             err
);

  dpCtrl_t    ctl;
  logic       byteDone;
  logic [7:0] rxByte;
  logic       gapBusy;
  logic       remZero;
  logic       lastSector;

  flashseq_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .opProg(opProg),
    .startAddr(startAddr), .byteLen(byteLen), .byteDone(byteDone),
    .rxByte(rxByte), .gapBusy(gapBusy), .remZero(remZero),
    .lastSector(lastSector), .ctl(ctl), .busy(busy), .done(done), .err(err)
  );

  flashseq_dp #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr),
    .byteLen(byteLen), .bufData(bufData), .spiMiso(spiMiso),
    .bufAddr(bufAddr), .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .byteDone(byteDone), .rxByte(rxByte), .gapBusy(gapBusy),
    .remZero(remZero), .lastSector(lastSector)
  );

endmodule

// File: rtl/spi_flash_prog_seq_chk.sv
module spi_flash_prog_seq_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic spiSck,
  input logic spiCsN,
  input logic busy,
  input logic done,
  input logic err
);

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck);

  assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> spiCsN);

  assert_err_no_job_R10: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !busy);

  assert_busy_from_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_not_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind spi_flash_prog_seq spi_flash_prog_seq_chk chk (
  .clk(clk), .rstN(rstN), .start(start), .spiSck(spiSck), .spiCsN(spiCsN),
  .busy(busy), .done(done), .err(err)
);

// File: tb/tb_spi_flash_prog_seq.sv
`timescale 1ns/1ps
module tb_spi_flash_prog_seq;

  localparam int CLK_DIV = 2;
  localparam int LEN_W   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic opProg = 1'b0;
  logic [23:0] startAddr = '0;
  logic [LEN_W-1:0] byteLen = '0;
  logic [LEN_W-1:0] bufAddr;
  logic [7:0] bufData;
  logic spiSck, spiCsN, spiMosi;
  logic spiMiso = 1'b0;
  logic busy, done, err;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_flash_prog_seq #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .opProg(opProg),
    .startAddr(startAddr), .byteLen(byteLen), .bufAddr(bufAddr),
    .bufData(bufData), .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .busy(busy), .done(done), .err(err)
  );

  logic [7:0] mem [0:255];
  assign bufData = mem[bufAddr[7:0]];

  // behavioural flash model
  int pollDelay = 0;
  int busyLeft = 0;
  logic wel = 1'b0;
  int bitCnt = 0;
  int txnLen = 0;
  logic [47:0] txnVal = '0;
  logic [7:0] inSh = '0;
  logic [7:0] cmd = '0;
  logic [7:0] outSh = '0;
  int logLen[$];
  logic [47:0] logVal[$];
  int expLen[$];
  logic [47:0] expVal[$];

  always @(negedge spiCsN or posedge spiSck) begin
    if (!spiSck) begin
      bitCnt = 0; txnLen = 0; txnVal = '0;
    end else if (!spiCsN) begin
      inSh = {inSh[6:0], spiMosi};
      bitCnt++;
      if (bitCnt % 8 == 0) begin
        txnVal = {txnVal[39:0], inSh};
        txnLen++;
        if (txnLen == 1) cmd = inSh;
      end
    end
  end

  always @(negedge spiSck or posedge spiCsN) begin
    if (spiCsN === 1'b1) begin
      spiMiso = 1'b0;
      if (txnLen > 0) begin
        logLen.push_back(txnLen);
        logVal.push_back(txnVal);
        case (cmd)
          8'h06: begin wel = 1'b1; busyLeft = pollDelay; end
          8'h04: begin wel = 1'b0; busyLeft = pollDelay; end
          8'hD7, 8'hAD: busyLeft = pollDelay;
          default: ;
        endcase
        txnLen = 0;
      end
    end else begin
      if (bitCnt == 8 && cmd == 8'h05) begin
        outSh = {6'b0, wel, (busyLeft > 0)};
        if (busyLeft > 0) busyLeft--;
        spiMiso = outSh[7];
      end else if (bitCnt > 8 && bitCnt < 16) begin
        outSh = {outSh[6:0], 1'b0};
        spiMiso = outSh[7];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock bus monitor
  int highCnt = 1000;
  logic prevCs = 1'b1;
  always @(negedge clk) begin
    if (rstN) begin
      check(!(spiCsN && spiSck), "R2 sck idle", {46'd0, spiCsN, spiSck}, 48'd2);
      if (prevCs && !spiCsN)
        check(highCnt >= 2 * CLK_DIV, "R2 cs gap", 48'(highCnt), 48'(2 * CLK_DIV));
      if (spiCsN) highCnt++; else highCnt = 0;
      prevCs = spiCsN;
    end
  end

  // expected sequence builders
  task automatic pushExp(input int n, input logic [47:0] v);
    expLen.push_back(n); expVal.push_back(v);
  endtask
  task automatic expPoll();
    for (int i = 0; i <= pollDelay; i++) pushExp(2, 48'h0500);
  endtask
  task automatic expErase(input logic [23:0] a, input int len);
    for (int s = 0; s < len / 1024; s++) begin
      pushExp(1, 48'h06); expPoll();
      pushExp(4, {16'h0, 8'hD7, a + 24'(s * 1024)}); expPoll();
      pushExp(1, 48'h04); expPoll();
    end
  endtask
  task automatic expProg(input logic [23:0] a, input int len);
    pushExp(1, 48'h06); expPoll();
    for (int w = 0; w < len / 2; w++) begin
      if (w == 0) pushExp(6, {8'hAD, a, mem[0], mem[1]});
      else pushExp(3, {24'h0, 8'hAD, mem[2 * w], mem[2 * w + 1]});
      expPoll();
    end
    pushExp(1, 48'h04); expPoll();
  endtask

  task automatic compareLog(input string tag);
    check(logLen.size() == expLen.size(), {tag, " frame count"}, 48'(logLen.size()), 48'(expLen.size()));
    for (int i = 0; i < expLen.size() && i < logLen.size(); i++)
      check(logLen[i] == expLen[i] && logVal[i] == expVal[i], tag,
            {logVal[i][43:0], 4'(logLen[i])}, {expVal[i][43:0], 4'(expLen[i])});
    logLen.delete(); logVal.delete(); expLen.delete(); expVal.delete();
  endtask

  task automatic pulseStart(input logic p, input logic [23:0] a, input int len);
    @(negedge clk);
    start = 1'b1; opProg = p; startAddr = a; byteLen = LEN_W'(len);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string tag, input int midStart);
    int n = 0;
    while (!done && n < 60000) begin
      @(negedge clk); n++;
      if (n == midStart) begin
        start = 1'b1; opProg = 1'b1; startAddr = 24'h000800; byteLen = LEN_W'(4);
        @(negedge clk); start = 1'b0; n++;
      end
    end
    check(done === 1'b1, {tag, " done seen"}, 48'(done), 48'd1);
    check(busy === 1'b0, "R12 busy low with done", 48'(busy), 48'd0);
    @(negedge clk);
    check(done === 1'b0, "R12 done one cycle", 48'(done), 48'd0);
  endtask

  task automatic runJob(input logic p, input logic [23:0] a, input int len, input string tag, input int midStart);
    logLen.delete(); logVal.delete();
    pulseStart(p, a, len);
    check(busy === 1'b1, "R12 busy after start", 48'(busy), 48'd1);
    check(err === 1'b0, "R10 err cleared on accept", 48'(err), 48'd0);
    waitDone(tag, midStart);
    compareLog(tag);
  endtask

  task automatic rejectCase(input logic p, input logic [23:0] a, input int len);
    logLen.delete(); logVal.delete();
    pulseStart(p, a, len);
    check(err === 1'b1, "R10 err raised", 48'(err), 48'd1);
    check(busy === 1'b0, "R10 stays idle", 48'(busy), 48'd0);
    repeat (60) @(negedge clk);
    check(logLen.size() == 0 && spiCsN === 1'b1, "R10 no bus activity", 48'(logLen.size()), 48'd0);
    check(err === 1'b1, "R10 err held", 48'(err), 48'd1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    check(spiCsN === 1'b1 && spiSck === 1'b0 && busy === 1'b0 && done === 1'b0 && err === 1'b0,
          "R1 in reset", {43'd0, spiCsN, spiSck, busy, done, err}, 48'h10);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(spiCsN === 1'b1 && spiSck === 1'b0 && busy === 1'b0 && done === 1'b0 && err === 1'b0,
          "R1 after reset", {43'd0, spiCsN, spiSck, busy, done, err}, 48'h10);

    // R3 R4 R8: single sector erase, immediate status
    pollDelay = 0; expErase(24'h001400, 1024);
    runJob(1'b0, 24'h001400, 1024, "R4 erase one sector", 0);

    // R5 R9: three sectors, status needs retries
    pollDelay = 2; expErase(24'h010000, 3072);
    runJob(1'b0, 24'h010000, 3072, "R5 erase multi sector", 0);

    // R6 R7: program four words, unaligned address
    pollDelay = 1; expProg(24'h000123, 8);
    runJob(1'b1, 24'h000123, 8, "R7 program words", 0);

    // R7: single word has no trailing word opcode
    pollDelay = 0; expProg(24'hABCDEF, 2);
    runJob(1'b1, 24'hABCDEF, 2, "R6 program one word", 0);

    // R9: long polling
    pollDelay = 9; expProg(24'h020000, 4);
    runJob(1'b1, 24'h020000, 4, "R9 long poll", 0);

    // R10: refused requests
    rejectCase(1'b1, 24'h000000, 5);
    rejectCase(1'b1, 24'h000000, 0);
    rejectCase(1'b0, 24'h000200, 1024);
    rejectCase(1'b0, 24'h000000, 768);

    // R11: start during busy ignored
    pollDelay = 1; expErase(24'h030000, 2048);
    runJob(1'b0, 24'h030000, 2048, "R11 start while busy", 40);
    repeat (300) @(negedge clk);
    check(busy === 1'b0 && logLen.size() == 0, "R11 no second job", 48'(logLen.size()), 48'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule